// File: doc/BRIEF.md
# System Reset Sequencer

This block gathers four reset requests into one reset for the chip core: a power-on request, an active-low external reset pin, a watchdog timeout pulse and a brown-out comparator output. The watchdog and brown-out requests each pass only when their own enable is set. The external pin passes only after it has stayed low for longer than a minimum number of clock cycles, so short glitches on the pin are ignored.

The I/O reset output follows the qualified requests directly, with no clock edge in the path. The core reset rises with the same requests. It is then held by a register. Once every request has cleared, a two-stage synchronizer and a delay counter release it. A static two-bit code selects the delay length. When the core reset drops, a one-cycle strobe marks the release so that the core can restart from its reset vector. A sticky register records which requests caused resets, and software clears it one bit at a time by writing ones.

Top module: `sysrst_merge`

## Requirements
- R1: While `por_req` is high, `io_rst` and `core_rst` are high and `rel_strobe` is low. After `por_req` falls, `cause_flags` reads 4'b0001.
- R2: The external source becomes active only when the pin is sampled low on more than `MIN_LOW` consecutive clock edges. A low pulse lasting `MIN_LOW` cycles or fewer has no effect on any output. With the pin held low, `io_rst` is observed high `MIN_LOW+2` cycles after the pin falls, and not one cycle earlier.
- R3: A `wdt_expire` pulse resets the chip only while `wdt_mode_en` is 1. With the enable at 0, it changes no output.
- R4: A high `bod_low` resets the chip only while `bod_en` is 1. With the enable at 0, it changes no output.
- R5: `io_rst` is high in any cycle where a power-on, enabled watchdog or enabled brown-out request is present, without waiting for a clock edge. It is also high while the external source is active.
- R6: `core_rst` stays high until 2+N clock edges after the first edge at which no request is present. N is 0 for `dly_sel` 2'b00, `DLY_SHORT` for 2'b01, `DLY_MID` for 2'b10 and `DLY_LONG` for 2'b11.
- R7: A request that appears while the delay is counting keeps `core_rst` high. Once all requests clear again, the full 2+N wait starts over.
- R8: `rel_strobe` is high for exactly one cycle per reset episode: the first cycle in which `core_rst` is low again.
- R9: `cause_flags` bit 0 is power-on, bit 1 external, bit 2 watchdog and bit 3 brown-out. A bit sets when its gated request is present at a clock edge and stays set.
- R10: Writing a 1 to a bit of `flag_clr` clears that flag on the next edge. If the source of that bit is present in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_req | input | 1 | Power-on reset request, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| wdt_mode_en | input | 1 | Enables watchdog system reset |
| bod_low | input | 1 | Brown-out comparator output, high when supply is low |
| bod_en | input | 1 | Enables the brown-out detector |
| dly_sel | input | 2 | Static release-delay select code |
| flag_clr | input | 4 | Write-one-to-clear strobes for cause_flags |
| io_rst | output | 1 | Immediate I/O reset, high while any qualified request is present |
| core_rst | output | 1 | Stretched core reset |
| rel_strobe | output | 1 | One-cycle pulse when core reset releases |
| cause_flags | output | 4 | Sticky reset cause record |

## Verification
The bench builds the block with `MIN_LOW`=3 and delays of 5, 9 and 40 cycles. With these values, every `dly_sel` code can be timed to the exact cycle in a short run, including the longest setting. The small filter width puts both sides of the glitch boundary in reach: a pulse of exactly three cycles, and one that lasts long enough to qualify. A request inserted partway through a five-cycle count shows that the wait restarts from zero.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        DLY_NONE  = 2'b00,
        DLY_SHORT = 2'b01,
        DLY_MID   = 2'b10,
        DLY_LONG  = 2'b11
    } dly_code_e;

    // Packed so that bit 0 is power-on, 1 external, 2 watchdog, 3 brown-out
    typedef struct packed {
        logic bod;
        logic wdt;
        logic ext;
        logic por;
    } src_vec_t;

    localparam int unsigned NUM_SRC = 4;

    function automatic int unsigned dly_len(
        input logic [1:0]  code,
        input int unsigned len_short,
        input int unsigned len_mid,
        input int unsigned len_long
    );
        case (dly_code_e'(code))
            DLY_NONE:  return 0;
            DLY_SHORT: return len_short;
            DLY_MID:   return len_mid;
            default:   return len_long;
        endcase
    endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int unsigned MIN_LOW = 4
) (
    input  logic clk,
    input  logic por_req,
    input  logic pin_n,
    output logic ext_active
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_LOW);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (por_req) begin
            sync_q    <= 2'b11;
            low_cnt_q <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_n};
            if (sync_q[1]) begin
                low_cnt_q <= '0;
            end else if (low_cnt_q != MIN_V) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign ext_active = !sync_q[1] && (low_cnt_q == MIN_V);

    // R2
    ext_qual_low_chk: assert property (@(posedge clk) disable iff (por_req)
        $rose(ext_active) |-> $past(!sync_q[1]));

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int unsigned DLY_SHORT = 16,
    parameter int unsigned DLY_MID   = 256,
    parameter int unsigned DLY_LONG  = 4096,
    parameter int unsigned CNT_W     = 13
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       src_any,
    input  logic [1:0] dly_sel,
    output logic       hold,
    output logic       rel_pulse
);
    import sysrst_pkg::*;

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;
    logic             hold_q;
    logic             rel_q;

    always_comb begin
        target = CNT_W'(dly_len(dly_sel, DLY_SHORT, DLY_MID, DLY_LONG));
    end

    always_ff @(posedge clk) begin
        if (src_any) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            hold_q <= 1'b1;
            rel_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], 1'b0};
            rel_q  <= 1'b0;
            if (!sync_q[1]) begin
                if (cnt_q >= target) begin
                    hold_q <= 1'b0;
                    rel_q  <= hold_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign hold      = hold_q;
    assign rel_pulse = rel_q;

    // R6
    hold_on_src_chk: assert property (@(posedge clk) disable iff (por_req)
        src_any |=> hold_q);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (por_req)
        cnt_q <= CNT_W'(DLY_LONG));

    // R8
    rel_after_hold_chk: assert property (@(posedge clk) disable iff (por_req)
        rel_q |-> (!hold_q && $past(hold_q)));

    // R8
    rel_single_chk: assert property (@(posedge clk) disable iff (por_req)
        rel_q |=> !rel_q);

endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             por_req,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] flags
);
    logic [N_SRC-1:0] flags_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (i == 0) begin : g_por
            always_ff @(posedge clk) begin
                if (por_req)         flags_q[i] <= 1'b1;
                else if (clr_vec[i]) flags_q[i] <= 1'b0;
            end
        end else begin : g_other
            always_ff @(posedge clk) begin
                if (por_req)         flags_q[i] <= 1'b0;
                else if (set_vec[i]) flags_q[i] <= 1'b1;
                else if (clr_vec[i]) flags_q[i] <= 1'b0;
            end
        end

        // R9
        flag_sticky_chk: assert property (@(posedge clk) disable iff (por_req)
            set_vec[i] |=> flags_q[i]);

        // R10
        flag_clear_chk: assert property (@(posedge clk) disable iff (por_req)
            (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);
    end

    assign flags = flags_q;

endmodule

// File: rtl/sysrst_merge.sv
module sysrst_merge #(
    parameter int unsigned MIN_LOW   = 4,
    parameter int unsigned DLY_SHORT = 16,
    parameter int unsigned DLY_MID   = 256,
    parameter int unsigned DLY_LONG  = 4096
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       ext_rst_n,
    input  logic       wdt_expire,
    input  logic       wdt_mode_en,
    input  logic       bod_low,
    input  logic       bod_en,
    input  logic [1:0] dly_sel,
    input  logic [3:0] flag_clr,
    output logic       io_rst,
    output logic       core_rst,
    output logic       rel_strobe,
    output logic [3:0] cause_flags
);
    import sysrst_pkg::*;

    localparam int unsigned CNT_W = $clog2(DLY_LONG + 1);

    src_vec_t src;
    logic     ext_active;
    logic     src_any;
    logic     hold;

    rst_pin_filter #(.MIN_LOW(MIN_LOW)) u_filter (
        .clk        (clk),
        .por_req    (por_req),
        .pin_n      (ext_rst_n),
        .ext_active (ext_active)
    );

    always_comb begin
        src.por = por_req;
        src.ext = ext_active;
        src.wdt = wdt_expire & wdt_mode_en;
        src.bod = bod_low & bod_en;
    end

    assign src_any = |src;

    rst_stretch #(
        .DLY_SHORT (DLY_SHORT),
        .DLY_MID   (DLY_MID),
        .DLY_LONG  (DLY_LONG),
        .CNT_W     (CNT_W)
    ) u_stretch (
        .clk       (clk),
        .por_req   (por_req),
        .src_any   (src_any),
        .dly_sel   (dly_sel),
        .hold      (hold),
        .rel_pulse (rel_strobe)
    );

    rst_cause_log #(.N_SRC(NUM_SRC)) u_log (
        .clk     (clk),
        .por_req (por_req),
        .set_vec (src),
        .clr_vec (flag_clr),
        .flags   (cause_flags)
    );

    assign io_rst   = src_any;
    assign core_rst = src_any | hold;

    // R8
    strobe_on_fall_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(core_rst) |-> rel_strobe);

endmodule

// File: tb/sysrst_merge_bench.sv
module sysrst_merge_bench;
    localparam int MIN_LOW = 3;
    localparam int D1 = 5;
    localparam int D2 = 9;
    localparam int D3 = 40;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       wdt_expire = 1'b0;
    logic       wdt_mode_en = 1'b0;
    logic       bod_low = 1'b0;
    logic       bod_en = 1'b0;
    logic [1:0] dly_sel = 2'b00;
    logic [3:0] flag_clr = 4'b0000;
    logic       io_rst, core_rst, rel_strobe;
    logic [3:0] cause_flags;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sysrst_merge #(.MIN_LOW(MIN_LOW), .DLY_SHORT(D1), .DLY_MID(D2), .DLY_LONG(D3)) u_sysrst_merge (
        .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdt_expire(wdt_expire),
        .wdt_mode_en(wdt_mode_en), .bod_low(bod_low), .bod_en(bod_en), .dly_sel(dly_sel),
        .flag_clr(flag_clr), .io_rst(io_rst), .core_rst(core_rst), .rel_strobe(rel_strobe),
        .cause_flags(cause_flags)
    );

    function automatic int n_of(input logic [1:0] c);
        case (c)
            2'b00: return 0;
            2'b01: return D1;
            2'b10: return D2;
            default: return D3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until core_rst drops; check strobe around the release
    task automatic wait_release(input string req, input int exp_n);
        int n = 0;
        int early = 0;
        do begin
            @(negedge clk);
            n++;
            if (core_rst && rel_strobe) early++;
        end while (core_rst && n < 6000);
        check(req, n, exp_n);
        check({req, " R8 strobe at release"}, int'(rel_strobe), 1);
        check({req, " R8 no early strobe"}, early, 0);
        @(negedge clk);
        check({req, " R8 strobe single"}, int'(rel_strobe), 0);
    endtask

    task automatic t_power_on();
        repeat (3) @(negedge clk);
        #1;
        check("R1 io_rst during por", int'(io_rst), 1);
        check("R1 core_rst during por", int'(core_rst), 1);
        check("R1 no strobe during por", int'(rel_strobe), 0);
        por_req = 1'b0;
        wait_release("R6 code 00 length", n_of(2'b00) + 3);
        check("R1 flags after por", int'(cause_flags), 4'b0001);
    endtask

    task automatic t_clear_flags();
        flag_clr = 4'b0001;
        @(negedge clk);
        flag_clr = 4'b0000;
        check("R10 clear por flag", int'(cause_flags), 4'b0000);
    endtask

    task automatic t_wdt(input logic en, input logic [1:0] code);
        dly_sel = code;
        wdt_mode_en = en;
        wdt_expire = 1'b1;
        #1;
        check("R5 R3 io_rst follows watchdog", int'(io_rst), int'(en));
        @(negedge clk);
        wdt_expire = 1'b0;
        if (en) begin
            wait_release("R6 R3 watchdog release", n_of(code) + 3);
            check("R9 watchdog flag", int'(cause_flags[2]), 1);
        end else begin
            repeat (4) @(negedge clk);
            check("R3 gated watchdog core_rst", int'(core_rst), 0);
            check("R3 gated watchdog flag", int'(cause_flags[2]), 0);
        end
        wdt_mode_en = 1'b0;
    endtask

    task automatic t_bod(input logic en, input logic [1:0] code);
        dly_sel = code;
        bod_en = en;
        bod_low = 1'b1;
        #1;
        check("R5 R4 io_rst follows brown-out", int'(io_rst), int'(en));
        repeat (2) @(negedge clk);
        bod_low = 1'b0;
        if (en) begin
            wait_release("R6 R4 brown-out release", n_of(code) + 3);
            check("R9 brown-out flag", int'(cause_flags[3]), 1);
        end else begin
            repeat (4) @(negedge clk);
            check("R4 gated brown-out core_rst", int'(core_rst), 0);
            check("R4 gated brown-out flag", int'(cause_flags[3]), 0);
        end
        bod_en = 1'b0;
    endtask

    task automatic t_ext_short();
        int seen = 0;
        ext_rst_n = 1'b0;
        repeat (MIN_LOW) @(negedge clk);
        ext_rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (io_rst || core_rst || rel_strobe) seen++;
        end
        check("R2 short pin pulse ignored", seen, 0);
        check("R2 short pulse leaves ext flag", int'(cause_flags[1]), 0);
    endtask

    task automatic t_ext_long(input logic [1:0] code);
        dly_sel = code;
        ext_rst_n = 1'b0;
        repeat (MIN_LOW + 1) @(negedge clk);
        check("R2 io_rst not yet", int'(io_rst), 0);
        @(negedge clk);
        check("R2 io_rst after qualify", int'(io_rst), 1);
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        wait_release("R6 R2 pin release", n_of(code) + 5);
        check("R9 external flag", int'(cause_flags[1]), 1);
    endtask

    task automatic t_restart();
        dly_sel = 2'b01;
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 still counting", int'(core_rst), 1);
        bod_en = 1'b1;
        bod_low = 1'b1;
        flag_clr = 4'b1000;
        @(negedge clk);
        bod_low = 1'b0;
        flag_clr = 4'b0000;
        check("R10 set wins over clear", int'(cause_flags[3]), 1);
        wait_release("R7 restarted count", n_of(2'b01) + 3);
        bod_en = 1'b0;
    endtask

    task automatic t_flag_clear_multi();
        flag_clr = 4'b1111;
        @(negedge clk);
        flag_clr = 4'b0000;
        check("R10 clear all flags", int'(cause_flags), 0);
    endtask

    initial begin
        t_power_on();
        t_clear_flags();
        t_wdt(1'b0, 2'b01);
        t_wdt(1'b1, 2'b01);
        t_bod(1'b0, 2'b10);
        t_bod(1'b1, 2'b10);
        t_bod(1'b1, 2'b11);
        t_flag_clear_multi();
        t_ext_short();
        t_ext_long(2'b10);
        t_restart();
        t_ext_long(2'b00);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule